// File: doc/BRIEF.md
# Call Instruction Cycle Sequencer

This block sequences one subroutine-call instruction of a small 8-bit processor with 16-bit addresses, one clock per T-state. It keeps the program counter and stack pointer. When idle and given a start pulse, it fetches the opcode from the memory bus at the current program counter. It reads the two target-address bytes that follow the opcode. If the call is taken, it pushes the return address (instruction address plus 3) onto a stack that grows downward, high byte first, and then jumps to the target.

The opcode fetch lasts six T-states. The bus read uses the first three. The last two produce a stack-pointer decrement, which is held as pending and is not yet committed. Each read or write machine cycle lasts three T-states, so a taken call takes 18 T-states. A conditional call tests its flag during the low-byte read. If the condition fails, the instruction ends after 9 T-states, the program counter skips the three instruction bytes, and the stack pointer is left unchanged.

Top module: `call_sequencer`

## Requirements
- R1: After reset the block is idle (busy low), mem_rd and mem_wr are low, pc equals RESET_PC (default 16'h0100) and sp equals RESET_SP (default 16'hFF00).
- R2: start is accepted only while busy is low. A start pulse during an instruction, including its last T-state, neither lengthens that instruction nor begins a new one.
- R3: The first machine cycle lasts 6 T-states. mem_rd is high with mem_addr = pc in T-states 1 to 3, the opcode is taken from mem_rdata at T-state 3, and no strobe is active in T-states 4 to 6.
- R4: For a taken call, machine cycle 2 reads the target low byte at pc+1 and machine cycle 3 reads the target high byte at pc+2. Each lasts 3 T-states with mem_rd high throughout.
- R5: For a taken call, machine cycle 4 writes the return-address high byte to sp-1, and machine cycle 5 writes the return-address low byte to sp-2. The return address is pc+3. Each write lasts 3 T-states with mem_wr high throughout.
- R6: done is a one-cycle pulse in the last T-state of the instruction. For a taken call this is T-state 18 counted from the first fetch T-state.
- R7: Opcode encoding: bit 0 = 1 means unconditional. Otherwise the call is taken when flags[opcode[3:1]] equals opcode[4]. flags is sampled in the last T-state of machine cycle 2.
- R8: A call whose condition fails ends with done at T-state 9. mem_wr never rises, sp is unchanged, and pc becomes pc+3.
- R9: After a taken call, pc equals {high byte, low byte} of the fetched target and sp equals its starting value minus 2.
- R10: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction at pc (ignored while busy) |
| flags | input | 8 | Condition flags, tested during machine cycle 2 |
| mem_rdata | input | 8 | Memory read data |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Last T-state of the instruction |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |

## Verification
The edge that accepts start puts the sequencer in fetch T-state 1. Bus activity for T-state n is therefore due n cycles after that edge. done is due at T-state 18 for a taken call and at T-state 9 for a failed one, and the new pc and sp are visible one cycle after done. The bench counts T-states from the accepting edge and samples every output on the falling edge, so each expectation is compared in the T-state it belongs to. It also drives extra start pulses at known T-states to confirm that those T-states are unchanged.

// File: rtl/call_seq_pkg.sv
package call_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [2:0] {
    MC_IDLE, MC_FETCH, MC_RD_LO, MC_RD_HI, MC_WR_HI, MC_WR_LO
  } mcycle_e;

  // bit0: unconditional; else flag[op[3:1]] must equal op[4]
  function automatic logic call_taken(input data_t op, input data_t flg);
    return op[0] | (flg[op[3:1]] == op[4]);
  endfunction

  function automatic addr_t return_addr(input addr_t pc_v);
    return pc_v + addr_t'(3);
  endfunction

  function automatic addr_t operand_addr(input addr_t pc_v, input int unsigned idx);
    return pc_v + addr_t'(idx);
  endfunction
endpackage

// File: rtl/call_seq_timer.sv
module call_seq_timer
  import call_seq_pkg::*;
#(
  parameter int T_FETCH = 6,
  parameter int T_MEM   = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    take,
  output mcycle_e mc,
  output logic [$clog2((T_FETCH > T_MEM ? T_FETCH : T_MEM) + 1)-1:0] tstate,
  output logic    last_t,
  output logic    done
);
  localparam int TMAX = (T_FETCH > T_MEM) ? T_FETCH : T_MEM;
  localparam int TW   = $clog2(TMAX + 1);

  function automatic int cycle_len(input mcycle_e m);
    return (m == MC_FETCH) ? T_FETCH : T_MEM;
  endfunction

  mcycle_e mc_next;

  assign last_t = (mc != MC_IDLE) && (tstate == TW'(cycle_len(mc) - 1));
  assign done   = last_t && ((mc == MC_RD_LO && !take) || mc == MC_WR_LO);

  always_comb begin
    unique case (mc)
      MC_FETCH: mc_next = MC_RD_LO;
      MC_RD_LO: mc_next = take ? MC_RD_HI : MC_IDLE;
      MC_RD_HI: mc_next = MC_WR_HI;
      MC_WR_HI: mc_next = MC_WR_LO;
      default:  mc_next = MC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc     <= MC_IDLE;
      tstate <= '0;
    end else if (mc == MC_IDLE) begin
      if (start) begin
        mc     <= MC_FETCH;
        tstate <= '0;
      end
    end else if (last_t) begin
      mc     <= mc_next;
      tstate <= '0;
    end else begin
      tstate <= tstate + TW'(1);
    end
  end

  assert_done_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (mc == MC_IDLE));

  assert_fetch_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mc == MC_RD_LO && $past(mc) == MC_FETCH) |-> ($past(tstate) == TW'(T_FETCH - 1)));

  assert_late_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mc == MC_WR_LO && last_t && start) |=> (mc == MC_IDLE));
endmodule

// File: rtl/call_seq_regs.sv
module call_seq_regs
  import call_seq_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0100,
  parameter logic [15:0] RESET_SP = 16'hFF00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_op,
  input  logic  ev_spdec,
  input  logic  ev_lo,
  input  logic  ev_hi,
  input  logic  ev_push_hi,
  input  logic  ev_skip,
  input  logic  ev_commit,
  input  data_t rdata,
  output addr_t pc,
  output addr_t sp,
  output addr_t sp_pend,
  output data_t op_q,
  output data_t tgt_lo,
  output data_t tgt_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= RESET_PC;
      sp      <= RESET_SP;
      sp_pend <= RESET_SP;
      op_q    <= '0;
      tgt_lo  <= '0;
      tgt_hi  <= '0;
    end else begin
      if (ev_op)      op_q    <= rdata;
      if (ev_spdec)   sp_pend <= sp - addr_t'(1);
      if (ev_lo)      tgt_lo  <= rdata;
      if (ev_hi)      tgt_hi  <= rdata;
      if (ev_push_hi) sp_pend <= sp_pend - addr_t'(1);
      if (ev_skip)    pc      <= return_addr(pc);
      if (ev_commit) begin
        pc <= {tgt_hi, tgt_lo};
        sp <= sp_pend;
      end
    end
  end

  assert_skip_keeps_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> $stable(sp));

  assert_commit_sp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> (sp == $past(sp) - addr_t'(2)));
endmodule

// File: rtl/call_seq_bus.sv
module call_seq_bus
  import call_seq_pkg::*;
#(
  parameter int T_MEM = 3,
  parameter int TW    = 3
) (
  input  mcycle_e       mc,
  input  logic [TW-1:0] tstate,
  input  addr_t         pc,
  input  addr_t         sp_pend,
  output addr_t         addr,
  output logic          rd,
  output logic          wr,
  output data_t         wdata
);
  addr_t ret;
  assign ret = return_addr(pc);

  always_comb begin
    addr  = pc;
    rd    = 1'b0;
    wr    = 1'b0;
    wdata = '0;
    unique case (mc)
      MC_FETCH: rd = (tstate < TW'(T_MEM));
      MC_RD_LO: begin addr = operand_addr(pc, 1); rd = 1'b1; end
      MC_RD_HI: begin addr = operand_addr(pc, 2); rd = 1'b1; end
      MC_WR_HI: begin addr = sp_pend; wr = 1'b1; wdata = ret[15:8]; end
      MC_WR_LO: begin addr = sp_pend; wr = 1'b1; wdata = ret[7:0]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/call_sequencer.sv
module call_sequencer
  import call_seq_pkg::*;
#(
  parameter int          T_FETCH  = 6,
  parameter int          T_MEM    = 3,
  parameter logic [15:0] RESET_PC = 16'h0100,
  parameter logic [15:0] RESET_SP = 16'hFF00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  flags,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc,
  output logic [15:0] sp
);
  localparam int TMAX = (T_FETCH > T_MEM) ? T_FETCH : T_MEM;
  localparam int TW   = $clog2(TMAX + 1);

  mcycle_e       mc;
  logic [TW-1:0] tstate;
  logic          last_t;
  logic          take;
  addr_t         sp_pend;
  data_t         op_q, tgt_lo, tgt_hi;

  // named internal events
  logic ev_op, ev_spdec, ev_lo, ev_hi, ev_push_hi, ev_skip, ev_commit;

  assign take       = call_taken(op_q, flags);
  assign ev_op      = (mc == MC_FETCH) && (tstate == TW'(T_MEM - 1));
  assign ev_spdec   = (mc == MC_FETCH) && last_t;
  assign ev_lo      = (mc == MC_RD_LO) && last_t;
  assign ev_hi      = (mc == MC_RD_HI) && last_t;
  assign ev_push_hi = (mc == MC_WR_HI) && last_t;
  assign ev_skip    = ev_lo && !take;
  assign ev_commit  = (mc == MC_WR_LO) && last_t;
  assign busy       = (mc != MC_IDLE);

  call_seq_timer #(.T_FETCH(T_FETCH), .T_MEM(T_MEM)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take),
    .mc(mc), .tstate(tstate), .last_t(last_t), .done(done)
  );

  call_seq_regs #(.RESET_PC(RESET_PC), .RESET_SP(RESET_SP)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ev_op(ev_op), .ev_spdec(ev_spdec), .ev_lo(ev_lo), .ev_hi(ev_hi),
    .ev_push_hi(ev_push_hi), .ev_skip(ev_skip), .ev_commit(ev_commit),
    .rdata(mem_rdata),
    .pc(pc), .sp(sp), .sp_pend(sp_pend),
    .op_q(op_q), .tgt_lo(tgt_lo), .tgt_hi(tgt_hi)
  );

  call_seq_bus #(.T_MEM(T_MEM), .TW(TW)) u_bus (
    .mc(mc), .tstate(tstate), .pc(pc), .sp_pend(sp_pend),
    .addr(mem_addr), .rd(mem_rd), .wr(mem_wr), .wdata(mem_wdata)
  );

  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_push_hi_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mc == MC_WR_HI) |-> (mem_addr == sp - 16'd1));

  assert_push_lo_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mc == MC_WR_LO) |-> (mem_addr == sp - 16'd2));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !mem_rd && !mem_wr));
endmodule

// File: tb/call_sequencer_tb.sv
module call_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  flags = 8'h00;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, busy, done;
  logic [7:0]  mem_wdata;
  logic [15:0] pc, sp;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [15:0] cur_pc;
  logic [7:0]  opc, tlo, thi;
  logic [15:0] m_pc = 16'h0100;
  logic [15:0] m_sp = 16'hFF00;

  always #5 clk = ~clk;

  call_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .flags(flags),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
    .pc(pc), .sp(sp)
  );

  always_comb begin
    if (mem_addr == cur_pc)              mem_rdata = opc;
    else if (mem_addr == cur_pc + 16'd1) mem_rdata = tlo;
    else if (mem_addr == cur_pc + 16'd2) mem_rdata = thi;
    else                                 mem_rdata = 8'h00;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One call instruction; extra_at = T-state index at which a stray start is driven (0 = none)
  task automatic run_call(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] flg, input int extra_at);
    bit taken;
    logic [15:0] ret;
    int done_at, done_cnt, bad_f, bad_r, bad_w, wr_cnt;
    taken = op[0] || (flg[op[3:1]] == op[4]);
    ret = m_pc + 16'd3;
    cur_pc = m_pc; opc = op; tlo = lo; thi = hi; flags = flg;
    done_at = 0; done_cnt = 0; bad_f = 0; bad_r = 0; bad_w = 0; wr_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int idx = 1; idx <= 20; idx++) begin
      if (mem_wr) wr_cnt++;
      if (done) begin done_cnt++; if (done_at == 0) done_at = idx; end
      if (idx <= 3) begin
        if (!(mem_rd && !mem_wr && mem_addr == m_pc)) bad_f++;
      end else if (idx <= 6) begin
        if (mem_rd || mem_wr) bad_f++;
      end else if (idx <= 9) begin
        if (!(mem_rd && mem_addr == m_pc + 16'd1)) bad_r++;
      end else if (idx <= 12 && taken) begin
        if (!(mem_rd && mem_addr == m_pc + 16'd2)) bad_r++;
      end else if (idx <= 15 && taken) begin
        if (!(mem_wr && !mem_rd && mem_addr == m_sp - 16'd1 && mem_wdata == ret[15:8])) bad_w++;
      end else if (idx <= 18 && taken) begin
        if (!(mem_wr && !mem_rd && mem_addr == m_sp - 16'd2 && mem_wdata == ret[7:0])) bad_w++;
      end
      start = (idx == extra_at);
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk) start = 1'b0;
    check(bad_f == 0, "R3 fetch cycle bus", bad_f, 0);
    check(bad_r == 0, "R4 operand reads", bad_r, 0);
    if (taken) begin
      check(bad_w == 0, "R5 return-address push", bad_w, 0);
      check(done_at == 18 && done_cnt == 1, "R6 done at T18", done_at, 18);
      check(pc == {hi, lo}, "R9 pc at target", pc, {hi, lo});
      check(sp == m_sp - 16'd2, "R9 sp minus 2", sp, m_sp - 16'd2);
      m_pc = {hi, lo}; m_sp = m_sp - 16'd2;
    end else begin
      check(done_at == 9 && done_cnt == 1, "R8 done at T9", done_at, 9);
      check(wr_cnt == 0, "R8 no write", wr_cnt, 0);
      check(pc == ret, "R8 pc plus 3", pc, ret);
      check(sp == m_sp, "R8 sp unchanged", sp, m_sp);
      m_pc = ret;
    end
    check(busy == 1'b0, "R2 idle after done", busy, 0);
    @(negedge clk);
    check(busy == 1'b0 && !mem_rd, "R2 stray start ignored", busy, 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_rd && !mem_wr && !done, "R1 idle after reset", busy, 0);
    check(pc == 16'h0100, "R1 reset pc", pc, 16'h0100);
    check(sp == 16'hFF00, "R1 reset sp", sp, 16'hFF00);
  endtask

  initial begin
    cur_pc = 16'h0100; opc = 8'h00; tlo = 8'h00; thi = 8'h00;
    test_reset();
    run_call(8'h01, 8'h56, 8'h34, 8'h00, 0);   // R7 unconditional
    run_call(8'h14, 8'h00, 8'h20, 8'h04, 0);   // R7 flag2 == 1 -> taken
    run_call(8'h14, 8'h11, 8'h22, 8'h00, 0);   // R7 flag2 != 1 -> skipped (R8)
    run_call(8'h0A, 8'h78, 8'h40, 8'h00, 0);   // R7 flag5 == 0 -> taken
    run_call(8'h0A, 8'h99, 8'h55, 8'h20, 0);   // R7 flag5 != 0 -> skipped (R8)
    run_call(8'h01, 8'h00, 8'h60, 8'h00, 5);   // R2 start mid-instruction
    run_call(8'h01, 8'h34, 8'h12, 8'h00, 18);  // R2 start in last T-state
    run_call(8'h14, 8'h00, 8'h70, 8'h00, 9);   // R2 start in last T-state of skip
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule